// File: doc/BRIEF.md
# SRAM Core Memory Bridge

This block lets a fast static RAM stand in for the core memory of an older processor. The processor has no handshake with its storage. It raises a select strobe and a use strobe to open a memory cycle. It then drives a read strobe for the first half of the cycle and a write strobe for the second half. It expects a pulse back on every sense line whose stored bit is 1, and after that it presents the word to be stored on its write-data bus. The bridge works out the cycle from those strobes alone and returns nothing except the sense pulses.

All four strobes pass through two-flop synchronizers. The address is latched when the cycle opens. After a fixed settle delay the bridge enables the RAM output for a fixed access window and captures the data lanes. It then drives the 1 bits onto the sense lines as pulses of fixed width. When the write strobe arrives, it captures the write-data bus, adds two parity bits (odd parity over each byte) and holds the RAM write enable for a fixed number of clocks. If select or use drops before the write, the bridge abandons the cycle and writes nothing.

Top module: `sram_core_bridge`

## Requirements
- R1: While `rst` is high and after its release with no strobes active, `sense_o` is zero and `ram_oe_o` and `ram_we_o` are low.
- R2: A cycle opens only when select and use are both high. The address present at that moment drives `ram_addr_o` for the whole time `ram_oe_o` is high.
- R3: In the read half, `sense_o` carries exactly the 16 stored data bits for exactly PULSE_CYC clocks. Bits stored as 0 never pulse, and a stored word of zero produces no pulse at all.
- R4: The sense pulse first appears after the rising clock edge numbered 3+SETTLE_CYC+ACCESS_CYC, counting the first edge after the read strobe rises as edge 1 (two synchronizer edges, one decision edge, then the settle and access windows).
- R5: `ram_oe_o` stays high for exactly ACCESS_CYC clocks per read, and it is never high together with `ram_we_o`.
- R6: After the write strobe rises, `ram_we_o` stays high for exactly WRITE_CYC clocks. During that time `ram_wdata_o[15:0]` equals the write-data bus.
- R7: `ram_wdata_o[16]` makes bits 7:0 plus itself hold an odd number of ones, and `ram_wdata_o[17]` does the same for bits 15:8.
- R8: If select or use falls before the write begins, the cycle is abandoned with no write enable, any sense pulse is cleared, and the next cycle behaves normally.
- R9: One cycle produces a single write-enable pulse, however long the write strobe stays high. The bridge waits for select or use to fall before it can open a new cycle.
- R10: Read and write strobes that arrive while select and use are not both high cause no RAM access and no sense pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_sel_i | input | 1 | Storage select strobe (asynchronous) |
| cyc_use_i | input | 1 | Storage use strobe (asynchronous) |
| cyc_rd_i | input | 1 | Read-half strobe (asynchronous) |
| cyc_wr_i | input | 1 | Write-half strobe (asynchronous) |
| cyc_addr_i | input | ADDR_W | Word address, stable before the cycle opens |
| cyc_wdata_i | input | 16 | Processor buffer contents to store |
| sense_o | output | 16 | Sense pulses, one line per data bit |
| ram_addr_o | output | ADDR_W | RAM address |
| ram_wdata_o | output | 18 | RAM write word: parity in 17:16, data in 15:0 |
| ram_rdata_i | input | 16 | RAM read data lanes (parity lanes are not read) |
| ram_oe_o | output | 1 | RAM output enable |
| ram_we_o | output | 1 | RAM write enable |

## Verification
The hardest case to reach is abandoning a cycle at the right moment. Select must fall late enough that the sequencer has left its armed state, yet early enough that the synchronizer delay still lands the drop before the RAM output enable or the write enable. The bench drives strobes one time unit after a falling edge, so every synchronizer delay is fixed. It lowers select three clocks into the settle window in one cycle, and between the sense pulse and the write strobe in another. Then it runs a normal cycle at the same address to confirm that the stored word did not change.

// File: rtl/cmb_pkg.sv
package cmb_pkg;

    localparam int DATA_W = 16;
    localparam int PAR_W  = 2;

    typedef struct packed {
        logic sel;
        logic usage;
        logic rd;
        logic wr;
    } strobe_t;

    typedef struct packed {
        logic [PAR_W-1:0]  par;
        logic [DATA_W-1:0] data;
    } ram_word_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_SETTLE,
        ST_ACCESS,
        ST_WAIT_WR,
        ST_WRITE,
        ST_HOLD
    } seq_state_e;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    // odd parity per byte: byte plus its parity bit holds an odd count of ones
    function automatic ram_word_t pack_word(input logic [DATA_W-1:0] d);
        ram_word_t w;
        w.data   = d;
        w.par[0] = ~^d[7:0];
        w.par[1] = ~^d[15:8];
        return w;
    endfunction

endpackage

// File: rtl/cmb_sync.sv
module cmb_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta_q;
        logic stab_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q <= 1'b0;
                stab_q <= 1'b0;
            end else begin
                meta_q <= d_i[i];
                stab_q <= meta_q;
            end
        end
        assign q_o[i] = stab_q;
    end

endmodule

// File: rtl/cmb_seq.sv
module cmb_seq
    import cmb_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int SETTLE_CYC = 2,
    parameter int ACCESS_CYC = 10,
    parameter int WRITE_CYC  = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  strobe_t           stb_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              load_o,
    output logic              abort_o,
    output logic              ram_oe_o,
    output logic              ram_we_o,
    output logic [ADDR_W-1:0] ram_addr_o,
    output ram_word_t         ram_word_o
);

    localparam int LONGEST = max3(SETTLE_CYC, ACCESS_CYC, WRITE_CYC);
    localparam int CNT_W   = $clog2(LONGEST + 1);

    seq_state_e        st_q, st_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic              active;
    logic              settle_end, access_end, write_end;
    logic [ADDR_W-1:0] addr_q;
    ram_word_t         word_q;
    logic              oe_q, we_q;

    assign active     = stb_i.sel & stb_i.usage;
    assign settle_end = (cnt_q == CNT_W'(SETTLE_CYC - 1));
    assign access_end = (cnt_q == CNT_W'(ACCESS_CYC - 1));
    assign write_end  = (cnt_q == CNT_W'(WRITE_CYC - 1));

    always_comb begin
        st_d    = st_q;
        cnt_d   = cnt_q + 1'b1;
        load_o  = 1'b0;
        abort_o = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                cnt_d = '0;
                if (active) st_d = ST_ARMED;
            end
            ST_ARMED: begin
                cnt_d = '0;
                if (stb_i.rd) st_d = ST_SETTLE;
            end
            ST_SETTLE: begin
                if (settle_end) begin
                    st_d  = ST_ACCESS;
                    cnt_d = '0;
                end
            end
            ST_ACCESS: begin
                if (access_end) begin
                    st_d   = ST_WAIT_WR;
                    cnt_d  = '0;
                    load_o = 1'b1;
                end
            end
            ST_WAIT_WR: begin
                cnt_d = '0;
                if (stb_i.wr) st_d = ST_WRITE;
            end
            ST_WRITE: begin
                if (write_end) begin
                    st_d  = ST_HOLD;
                    cnt_d = '0;
                end
            end
            ST_HOLD: begin
                cnt_d = '0;
            end
            default: begin
                st_d  = ST_IDLE;
                cnt_d = '0;
            end
        endcase
        // losing select or use ends any open cycle at once
        if (st_q != ST_IDLE && !active) begin
            st_d    = ST_IDLE;
            cnt_d   = '0;
            load_o  = 1'b0;
            abort_o = (st_q != ST_HOLD);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            cnt_q  <= '0;
            addr_q <= '0;
            word_q <= '0;
            oe_q   <= 1'b0;
            we_q   <= 1'b0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            oe_q  <= (st_d == ST_ACCESS);
            we_q  <= (st_d == ST_WRITE);
            if (st_q == ST_IDLE && active) addr_q <= addr_i;
            if (st_q == ST_WAIT_WR && st_d == ST_WRITE) word_q <= pack_word(wdata_i);
        end
    end

    assign ram_oe_o   = oe_q;
    assign ram_we_o   = we_q;
    assign ram_addr_o = addr_q;
    assign ram_word_o = word_q;

endmodule

// File: rtl/cmb_sense.sv
module cmb_sense
    import cmb_pkg::*;
#(
    parameter int PULSE_CYC = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic              clr_i,
    input  logic [DATA_W-1:0] bits_i,
    output logic [DATA_W-1:0] sense_o
);

    localparam int CW = $clog2(PULSE_CYC + 1);

    logic [CW-1:0]     left_q;
    logic [DATA_W-1:0] sense_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            left_q  <= '0;
            sense_q <= '0;
        end else if (load_i) begin
            left_q  <= CW'(PULSE_CYC - 1);
            sense_q <= bits_i;
        end else if (left_q != '0) begin
            left_q  <= left_q - 1'b1;
        end else begin
            sense_q <= '0;
        end
    end

    assign sense_o = sense_q;

endmodule

// File: rtl/sram_core_bridge.sv
module sram_core_bridge
    import cmb_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int SETTLE_CYC = 2,
    parameter int ACCESS_CYC = 10,
    parameter int PULSE_CYC  = 10,
    parameter int WRITE_CYC  = 10
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cyc_sel_i,
    input  logic                      cyc_use_i,
    input  logic                      cyc_rd_i,
    input  logic                      cyc_wr_i,
    input  logic [ADDR_W-1:0]         cyc_addr_i,
    input  logic [15:0]               cyc_wdata_i,
    output logic [15:0]               sense_o,
    output logic [ADDR_W-1:0]         ram_addr_o,
    output logic [DATA_W+PAR_W-1:0]   ram_wdata_o,
    input  logic [15:0]               ram_rdata_i,
    output logic                      ram_oe_o,
    output logic                      ram_we_o
);

    localparam int N_STB = $bits(strobe_t);

    logic [N_STB-1:0] stb_raw, stb_sync;
    strobe_t          stb_s;
    logic             load, abort;
    ram_word_t        word;

    assign stb_raw = {cyc_sel_i, cyc_use_i, cyc_rd_i, cyc_wr_i};
    assign stb_s   = strobe_t'(stb_sync);

    cmb_sync #(.W(N_STB)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (stb_raw),
        .q_o (stb_sync)
    );

    cmb_seq #(
        .ADDR_W     (ADDR_W),
        .SETTLE_CYC (SETTLE_CYC),
        .ACCESS_CYC (ACCESS_CYC),
        .WRITE_CYC  (WRITE_CYC)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .stb_i      (stb_s),
        .addr_i     (cyc_addr_i),
        .wdata_i    (cyc_wdata_i),
        .load_o     (load),
        .abort_o    (abort),
        .ram_oe_o   (ram_oe_o),
        .ram_we_o   (ram_we_o),
        .ram_addr_o (ram_addr_o),
        .ram_word_o (word)
    );

    cmb_sense #(.PULSE_CYC(PULSE_CYC)) u_sense (
        .clk     (clk),
        .rst     (rst),
        .load_i  (load),
        .clr_i   (abort),
        .bits_i  (ram_rdata_i),
        .sense_o (sense_o)
    );

    assign ram_wdata_o = word;

endmodule

// File: rtl/cmb_checker.sv
module cmb_checker
    import cmb_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int PULSE_CYC = 10,
    parameter int WRITE_CYC = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              oe,
    input logic              we,
    input logic [15:0]       sense,
    input logic [ADDR_W-1:0] addr,
    input strobe_t           stb
);

    int unsigned sense_run;
    int unsigned we_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            sense_run <= 0;
            we_run    <= 0;
        end else begin
            sense_run <= (sense != '0) ? sense_run + 1 : 0;
            we_run    <= we ? we_run + 1 : 0;
        end
    end

    // R5: output enable and write enable never overlap
    p_oe_we_excl_r5: assert property (@(posedge clk) disable iff (rst)
        !(oe && we));

    // R3: a sense pulse is never wider than PULSE_CYC
    p_sense_width_r3: assert property (@(posedge clk) disable iff (rst)
        sense_run <= PULSE_CYC);

    // R6: write enable is never held past WRITE_CYC
    p_we_width_r6: assert property (@(posedge clk) disable iff (rst)
        we_run <= WRITE_CYC);

    // R8: a write only starts inside an open cycle with the write strobe seen
    p_we_in_cycle_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(we) |-> $past(stb.sel && stb.usage && stb.wr));

    // R4: sense pulses begin right after a RAM read window
    p_sense_after_oe_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(sense != '0) |-> $past(oe));

    // R2: address holds still throughout a read window
    p_addr_stable_r2: assert property (@(posedge clk) disable iff (rst)
        (oe && $past(oe)) |-> $stable(addr));

endmodule

bind sram_core_bridge cmb_checker #(
    .ADDR_W    (ADDR_W),
    .PULSE_CYC (PULSE_CYC),
    .WRITE_CYC (WRITE_CYC)
) u_chk (
    .clk   (clk),
    .rst   (rst),
    .oe    (ram_oe_o),
    .we    (ram_we_o),
    .sense (sense_o),
    .addr  (ram_addr_o),
    .stb   (stb_s)
);

// File: tb/sram_core_bridge_bench.sv
module sram_core_bridge_bench;

    localparam int CLK_PERIOD = 10;
    localparam int AW    = 4;
    localparam int DEPTH = 1 << AW;
    localparam int S = 4;
    localparam int A = 5;
    localparam int P = 3;
    localparam int W = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             sel = 1'b0, usep = 1'b0, rd = 1'b0, wr = 1'b0;
    logic [AW-1:0]    addr = '0;
    logic [15:0]      wdata = '0;
    logic [15:0]      sense;
    logic [AW-1:0]    ram_addr;
    logic [17:0]      ram_wdata;
    logic [15:0]      ram_rdata;
    logic             ram_oe, ram_we;

    logic [17:0]      ram     [DEPTH];
    logic [15:0]      exp_mem [DEPTH];

    int total = 0, fails = 0;
    int edge_no = 0;
    int oe_n, we_n, we_rises, sense_n, sense_bad, addr_bad, first_edge;
    logic [15:0] sense_or, exp_sense;
    logic [AW-1:0] exp_addr;
    logic we_prev = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_core_bridge #(
        .ADDR_W(AW), .SETTLE_CYC(S), .ACCESS_CYC(A), .PULSE_CYC(P), .WRITE_CYC(W)
    ) u_sram_core_bridge (
        .clk(clk), .rst(rst),
        .cyc_sel_i(sel), .cyc_use_i(usep), .cyc_rd_i(rd), .cyc_wr_i(wr),
        .cyc_addr_i(addr), .cyc_wdata_i(wdata),
        .sense_o(sense), .ram_addr_o(ram_addr), .ram_wdata_o(ram_wdata),
        .ram_rdata_i(ram_rdata), .ram_oe_o(ram_oe), .ram_we_o(ram_we)
    );

    // RAM model
    always @(posedge clk) if (ram_we) ram[ram_addr] <= ram_wdata;
    assign ram_rdata = ram_oe ? ram[ram_addr][15:0] : 16'h0;

    always @(posedge clk) edge_no++;

    always @(negedge clk) begin
        if (ram_oe) begin
            oe_n++;
            if (ram_addr != exp_addr) addr_bad++;
        end
        if (ram_we) we_n++;
        if (ram_we && !we_prev) we_rises++;
        we_prev = ram_we;
        if (sense != 16'h0) begin
            sense_n++;
            sense_or |= sense;
            if (sense != exp_sense) sense_bad++;
            if (first_edge < 0) first_edge = edge_no;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic clear_mon();
        oe_n = 0; we_n = 0; we_rises = 0; sense_n = 0; sense_bad = 0;
        addr_bad = 0; first_edge = -1; sense_or = 16'h0;
    endtask

    function automatic logic [15:0] pat(input int a, input int pass);
        logic [15:0] v;
        if (a == 0) v = 16'hFFFF;
        else if (a == 1) v = 16'h0001;
        else v = 16'((a * 16'h1F3B) ^ 16'h5A5A);
        return (pass == 0) ? v : ~v;
    endfunction

    // mode 0: full cycle, 1: drop select in settle window, 2: drop select before write
    task automatic mem_cycle(input int a, input logic [15:0] wd, input int mode);
        int t0;
        exp_addr  = AW'(a);
        exp_sense = exp_mem[a];
        clear_mon();
        addr = AW'(a);
        wdata = wd;
        tick(2);
        sel = 1'b1; usep = 1'b1;
        tick(3);
        rd = 1'b1;
        t0 = edge_no;
        if (mode == 1) begin
            tick(3);
            sel = 1'b0;
            tick(S + A + P + 8);
            rd = 1'b0; usep = 1'b0;
            tick(4);
            chk(oe_n == 0, "R8 no read after early abort", oe_n, 0);
            chk(sense_n == 0, "R8 no sense after early abort", sense_n, 0);
            chk(we_n == 0, "R8 no write after early abort", we_n, 0);
            return;
        end
        tick(3 + S + A + P + 4);
        chk(sense_or == exp_sense, "R3 sense bit pattern", sense_or, exp_sense);
        chk(sense_bad == 0, "R3 sense samples match word", sense_bad, 0);
        chk(sense_n == ((exp_sense != 0) ? P : 0), "R3 sense width", sense_n, (exp_sense != 0) ? P : 0);
        if (exp_sense != 0)
            chk(first_edge - t0 == 3 + S + A, "R4 sense latency", first_edge - t0, 3 + S + A);
        chk(oe_n == A, "R5 output enable width", oe_n, A);
        chk(addr_bad == 0, "R2 address during read", addr_bad, 0);
        if (mode == 2) begin
            sel = 1'b0; rd = 1'b0;
            tick(2);
            wr = 1'b1;
            tick(W + 8);
            wr = 1'b0; usep = 1'b0;
            tick(4);
            chk(we_n == 0, "R8 no write after late abort", we_n, 0);
            chk(ram[a][15:0] == exp_mem[a], "R8 stored word unchanged", ram[a][15:0], exp_mem[a]);
            return;
        end
        rd = 1'b0;
        tick(1);
        wr = 1'b1;
        tick(3 + W + 10);
        chk(we_rises == 1, "R9 single write pulse", we_rises, 1);
        chk(we_n == W, "R6 write enable width", we_n, W);
        chk(ram[a][15:0] == wd, "R6 stored data", ram[a][15:0], wd);
        chk(ram[a][16] == ~^wd[7:0], "R7 low byte parity", ram[a][16], ~^wd[7:0]);
        chk(ram[a][17] == ~^wd[15:8], "R7 high byte parity", ram[a][17], ~^wd[15:8]);
        exp_mem[a] = wd;
        wr = 1'b0;
        tick(2);
        sel = 1'b0; usep = 1'b0;
        tick(4);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog actual=expired expected=done");
        finish_run();
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            ram[i] = 18'h0;
            exp_mem[i] = 16'h0;
        end
        clear_mon();
        exp_sense = 16'h0;
        exp_addr = '0;
        tick(3);
        chk(sense == 0 && !ram_oe && !ram_we, "R1 outputs in reset", {sense, ram_oe, ram_we}, 0);
        rst = 1'b0;
        tick(5);
        chk(sense == 0 && !ram_oe && !ram_we, "R1 outputs after reset", {sense, ram_oe, ram_we}, 0);

        // R10: strobes without both select and use
        clear_mon();
        sel = 1'b0; usep = 1'b1; rd = 1'b1;
        tick(20);
        rd = 1'b0; wr = 1'b1;
        tick(20);
        wr = 1'b0; usep = 1'b0; sel = 1'b1; rd = 1'b1;
        tick(20);
        rd = 1'b0; wr = 1'b1;
        tick(20);
        wr = 1'b0; sel = 1'b0;
        tick(4);
        chk(oe_n == 0 && sense_n == 0, "R10 no read without cycle", oe_n + sense_n, 0);
        chk(we_n == 0, "R10 no write without cycle", we_n, 0);

        // sweeps: fill, overwrite, read back
        for (int pass = 0; pass < 2; pass++)
            for (int a = 0; a < DEPTH; a++)
                mem_cycle(a, pat(a, pass), 0);
        for (int a = 0; a < DEPTH; a++)
            mem_cycle(a, 16'h0000, 0);

        // R8: abandoned cycles, then recovery at the same addresses
        mem_cycle(3, 16'hAAAA, 0);
        mem_cycle(3, 16'h1234, 1);
        mem_cycle(3, 16'hBEEF, 2);
        mem_cycle(3, 16'h0F0F, 0);
        mem_cycle(3, 16'h8001, 0);

        finish_run();
    end

endmodule